// File: doc/BRIEF.md
# Reload-Base PWM Timer

This block generates a pulse-width modulated output from an up-counter of configurable width (32 bits by default). A single period starts with the counter at a programmed base value. The counter then steps up by one each clock until it holds all-ones, and on the next clock it returns to the base. The output is at its active level while the count lies between the base and a programmed threshold, both ends included. It is at its inactive level from the threshold up to all-ones.

Software uses a small write port with three registers: the base, the threshold, and a control word with a run bit and an invert bit. The safe way to reconfigure is to stop the timer, write the new values and start it again. If base or threshold are written while the timer runs, they are held as pending values and only take effect at the next return to the base. The period in progress is never cut short or stretched.

Top module: `pwm_reload_timer`

## Requirements
- R1: While running, the counter rises by one per clock; on the clock after it holds all-ones it takes the base value, so the waveform repeats period after period.
- R2: One period lasts (all-ones − base + 1) clocks.
- R3: The active phase lasts (threshold − base + 1) clocks and is the first phase of each period, starting in the cycle where the count equals the base.
- R4: The inactive phase lasts (all-ones − threshold) clocks and ends at the return to the base.
- R5: The smallest useful base is all-ones minus one, giving a two-clock period; base 0xFFFFFFFC with threshold 0xFFFFFFFD gives a four-clock period with two active clocks.
- R6: Write port: address 0 writes the base, address 1 the threshold, address 2 the control word (bit 0 run, bit 1 invert); address 3 writes nothing. After reset the base and threshold are 0xFFFFFFFE, the timer is stopped and invert is 0.
- R7: Writing run = 1 while stopped loads the counter with the base, and the output is active in the first cycle after that write.
- R8: Base or threshold writes made while running do not change the current period; they apply from the next return to the base.
- R9: While stopped the output sits at the inactive level; writing run = 0 stops the timer and the output is inactive from the next cycle on.
- R10: With invert = 0 the active level is 1; with invert = 1 it is 0, and the invert bit takes effect in the cycle after its write.
- R11: A threshold of all-ones keeps the output active for the whole period; a threshold below the base keeps it inactive for the whole period.
- R12: Writing run = 1 while already running does not restart the counter or disturb the waveform.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (0 base, 1 threshold, 2 control, 3 none) |
| wr_data | input | W | Write data |
| pwm_out | output | 1 | PWM output |

## Verification
The bench drives the two-clock minimum period and the four-clock half-duty pair. A counter that reloads one step late would stretch those periods, and one that drops the +1 would shorten the active phase. It also drives the threshold at all-ones and below the base. A design that compares on the wrong side would then toggle when it should stay fixed, or wrap the comparison. Base and threshold are rewritten in the middle of a period. A design that applies them at once would cut the current period short, which shows as an early edge. A repeated start while running is issued too, and a design that restarts on it would show a second active phase out of turn.

// File: rtl/pwm_tmr_pkg.sv
`timescale 1ns/1ps
// Package: shared register selectors and control-word bit positions for
// the reload-base PWM timer. Assumes a 2-bit register address.
package pwm_tmr_pkg;
    localparam int unsigned SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_BASE   = 2'd0,
        SEL_THRESH = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    localparam int unsigned CTRL_RUN_POS = 0;
    localparam int unsigned CTRL_INV_POS = 1;
endpackage

// File: rtl/pwm_tmr_regs.sv
`timescale 1ns/1ps
// Register file: decodes the write port into pending base/threshold values
// and the invert bit, and forwards control-word writes as an event with
// the requested run bit. Assumes W >= 2.
module pwm_tmr_regs
    import pwm_tmr_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_addr,
    input  logic [W-1:0]     wr_data,
    output logic [W-1:0]     base_pend,
    output logic [W-1:0]     thr_pend,
    output logic             inv_q,
    output logic             ctrl_wr,
    output logic             ctrl_run
);
    localparam logic [W-1:0] RST_VAL = {{(W-1){1'b1}}, 1'b0};

    reg_sel_e sel;

    // Decode the register select and the control-word event.
    always_comb begin
        sel      = reg_sel_e'(wr_addr);
        ctrl_wr  = wr_en && (sel == SEL_CTRL);
        ctrl_run = wr_data[CTRL_RUN_POS];
    end

    // Hold the pending base, pending threshold and invert bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_pend <= RST_VAL;
            thr_pend  <= RST_VAL;
            inv_q     <= 1'b0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_BASE:   base_pend <= wr_data;
                SEL_THRESH: thr_pend  <= wr_data;
                SEL_CTRL:   inv_q     <= wr_data[CTRL_INV_POS];
                default:    ;
            endcase
        end
    end
endmodule

// File: rtl/pwm_tmr_counter.sv
`timescale 1ns/1ps
// Counter core: keeps the run state and the up-counter, and the base and
// threshold copies in use for the current period. The copies are taken
// from the pending values only at start and at each return to the base,
// so mid-period writes never touch the running period.
module pwm_tmr_counter #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ctrl_wr,
    input  logic         ctrl_run,
    input  logic [W-1:0] base_pend,
    input  logic [W-1:0] thr_pend,
    output logic         run_q,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] base_cur,
    output logic [W-1:0] thr_cur
);
    localparam logic [W-1:0] TOP     = {W{1'b1}};
    localparam logic [W-1:0] RST_VAL = {{(W-1){1'b1}}, 1'b0};

    logic start_ev;
    logic stop_ev;
    logic at_top;

    // Classify the control write and the wrap point.
    always_comb begin
        start_ev = ctrl_wr && ctrl_run && !run_q;
        stop_ev  = ctrl_wr && !ctrl_run;
        at_top   = (cnt_q == TOP);
    end

    // Advance, reload, start or stop the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            cnt_q    <= RST_VAL;
            base_cur <= RST_VAL;
            thr_cur  <= RST_VAL;
        end else if (start_ev) begin
            run_q    <= 1'b1;
            cnt_q    <= base_pend;
            base_cur <= base_pend;
            thr_cur  <= thr_pend;
        end else if (stop_ev) begin
            run_q    <= 1'b0;
        end else if (run_q) begin
            if (at_top) begin
                cnt_q    <= base_pend;
                base_cur <= base_pend;
                thr_cur  <= thr_pend;
            end else begin
                cnt_q    <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pwm_tmr_outstage.sv
`timescale 1ns/1ps
// Output stage: the output is active while the count is at or below the
// threshold in use. Assumes the count never drops below the base in use,
// which the counter core guarantees, so a threshold below the base yields
// no active cycles. Applies the invert bit and forces the inactive level
// while stopped.
module pwm_tmr_outstage #(
    parameter int unsigned W = 32
) (
    input  logic         run_q,
    input  logic         inv_q,
    input  logic [W-1:0] cnt_q,
    input  logic [W-1:0] thr_cur,
    output logic         pwm_out
);
    logic in_window;

    // Compare the count against the threshold and apply polarity.
    always_comb begin
        in_window = run_q && (cnt_q <= thr_cur);
        pwm_out   = in_window ^ inv_q;
    end
endmodule

// File: rtl/pwm_reload_timer.sv
`timescale 1ns/1ps
// Top: reload-base PWM timer. Connects the register file, counter core and
// output stage. Every output-affecting state is a flop; pwm_out is a
// shallow combinational function of flops.
module pwm_reload_timer
    import pwm_tmr_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_addr,
    input  logic [W-1:0]     wr_data,
    output logic             pwm_out
);
    logic [W-1:0] base_pend;
    logic [W-1:0] thr_pend;
    logic         inv_q;
    logic         ctrl_wr;
    logic         ctrl_run;
    logic         run_q;
    logic [W-1:0] cnt_q;
    logic [W-1:0] base_cur;
    logic [W-1:0] thr_cur;

    pwm_tmr_regs #(.W(W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .base_pend (base_pend),
        .thr_pend  (thr_pend),
        .inv_q     (inv_q),
        .ctrl_wr   (ctrl_wr),
        .ctrl_run  (ctrl_run)
    );

    pwm_tmr_counter #(.W(W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .ctrl_run  (ctrl_run),
        .base_pend (base_pend),
        .thr_pend  (thr_pend),
        .run_q     (run_q),
        .cnt_q     (cnt_q),
        .base_cur  (base_cur),
        .thr_cur   (thr_cur)
    );

    pwm_tmr_outstage #(.W(W)) u_out (
        .run_q   (run_q),
        .inv_q   (inv_q),
        .cnt_q   (cnt_q),
        .thr_cur (thr_cur),
        .pwm_out (pwm_out)
    );
endmodule

// File: rtl/pwm_tmr_chk.sv
`timescale 1ns/1ps
// Checker: temporal properties of the reload-base PWM timer, bound to the
// top module. Observes only; drives nothing.
module pwm_tmr_chk #(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         run_q,
    input logic         inv_q,
    input logic [W-1:0] cnt_q,
    input logic [W-1:0] base_cur,
    input logic [W-1:0] thr_cur,
    input logic [W-1:0] base_pend,
    input logic         pwm_out
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    // R1: steady counting by one below the top
    a_r1_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && cnt_q != TOP) |=> (!run_q || cnt_q == W'($past(cnt_q) + 1'b1)));

    // R1: after the top the counter takes the pending base
    a_r1_wrap_to_base: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && cnt_q == TOP) |=> (!run_q || cnt_q == $past(base_pend)));

    // R8: copies in use stay fixed inside a period
    a_r8_period_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && cnt_q != TOP) |=> (!run_q || ($stable(base_cur) && $stable(thr_cur))));

    // R3: the first cycle of a period is active when threshold >= base
    a_r3_base_active: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && cnt_q == base_cur && thr_cur >= base_cur) |-> (pwm_out != inv_q));

    // R9: stopped timer holds the inactive level
    a_r9_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> (pwm_out == inv_q));

    // R11: threshold at the top keeps the output active
    a_r11_full_on: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && thr_cur == TOP) |-> (pwm_out != inv_q));

    // R11: threshold below the base keeps the output inactive
    a_r11_full_off: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && thr_cur < base_cur) |-> (pwm_out == inv_q));
endmodule

bind pwm_reload_timer pwm_tmr_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_q     (run_q),
    .inv_q     (inv_q),
    .cnt_q     (cnt_q),
    .base_cur  (base_cur),
    .thr_cur   (thr_cur),
    .base_pend (base_pend),
    .pwm_out   (pwm_out)
);

// File: tb/sim_pwm_reload_timer.sv
`timescale 1ns/1ps
// Bench: behavioural cycle model compared on every clock, plus directed
// period/duty checks computed from the requirement formulas.
module sim_pwm_reload_timer;
    localparam longint ONES = 64'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic        pwm_out;

    int checks = 0;
    int failures = 0;
    string cur_tag = "R1";

    // reference model state
    bit     m_run, m_pol;
    longint m_cnt, m_ldp, m_mtp, m_ld, m_mt;

    pwm_reload_timer u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pwm_out (pwm_out)
    );

    always #2.5 clk = ~clk;

    task automatic chk(string tag, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: pwm_out=%b expected=%b at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic void model_step(bit we, logic [1:0] a, logic [31:0] d);
        bit     n_run = m_run, n_pol = m_pol;
        longint n_cnt = m_cnt, n_ldp = m_ldp, n_mtp = m_mtp, n_ld = m_ld, n_mt = m_mt;
        bit     is_ctrl = we && (a == 2'd2);
        if (!rst_n) begin
            m_run = 0; m_pol = 0; m_cnt = ONES - 1;
            m_ldp = ONES - 1; m_mtp = ONES - 1; m_ld = ONES - 1; m_mt = ONES - 1;
            return;
        end
        if (is_ctrl && d[0] && !m_run) begin
            n_run = 1; n_cnt = m_ldp; n_ld = m_ldp; n_mt = m_mtp;
        end else if (is_ctrl && !d[0]) begin
            n_run = 0;
        end else if (m_run) begin
            if (m_cnt == ONES) begin
                n_cnt = m_ldp; n_ld = m_ldp; n_mt = m_mtp;
            end else begin
                n_cnt = m_cnt + 1;
            end
        end
        if (we && a == 2'd0) n_ldp = longint'(d);
        if (we && a == 2'd1) n_mtp = longint'(d);
        if (is_ctrl) n_pol = d[1];
        m_run = n_run; m_pol = n_pol; m_cnt = n_cnt;
        m_ldp = n_ldp; m_mtp = n_mtp; m_ld = n_ld; m_mt = n_mt;
    endfunction

    function automatic logic model_out();
        if (!m_run) return m_pol;
        return logic'(m_cnt <= m_mt) ^ m_pol;
    endfunction

    // One clock: drive at the falling edge, update model after the rising
    // edge, compare at the next falling edge.
    task automatic tick(bit we, logic [1:0] a, logic [31:0] d);
        wr_en = we; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        model_step(we, a, d);
        wr_en = 1'b0;
        chk({cur_tag, " model"}, pwm_out, model_out());
    endtask

    task automatic idle();
        tick(1'b0, 2'd0, 32'd0);
    endtask

    // Stop, program, start, then check three periods against the formulas.
    task automatic run_pair(logic [31:0] ld, logic [31:0] mt, int per, int act, bit pol,
                            string tag);
        cur_tag = tag;
        tick(1'b1, 2'd2, {30'd0, pol, 1'b0});
        tick(1'b1, 2'd0, ld);
        tick(1'b1, 2'd1, mt);
        tick(1'b1, 2'd2, {30'd0, pol, 1'b1});
        chk("R7 active right after start", pwm_out, (act > 0) ^ pol);
        for (int k = 0; k < 3 * per; k++) begin
            chk({tag, " formula"}, pwm_out, ((k % per) < act) ^ pol);
            idle();
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not finish, got=hung expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        model_step(1'b0, 2'd0, 32'd0);
        @(negedge clk);
        repeat (3) idle();
        rst_n = 1'b1;
        cur_tag = "R6";
        idle();
        chk("R6 reset level", pwm_out, 1'b0);
        // R6: address 3 writes nothing; start then runs the reset base/threshold
        tick(1'b1, 2'd3, 32'h0000_0000);
        tick(1'b1, 2'd2, 32'h1);
        for (int k = 0; k < 6; k++) begin
            chk("R6 reset values 2/1", pwm_out, (k % 2) == 0);
            idle();
        end

        run_pair(32'hFFFF_FFFC, 32'hFFFF_FFFD, 4, 2, 1'b0, "R5");
        run_pair(32'hFFFF_FFFE, 32'hFFFF_FFFE, 2, 1, 1'b0, "R5 min");
        run_pair(32'hFFFF_FFF6, 32'hFFFF_FFF8, 10, 3, 1'b0, "R2 R3 R4");
        run_pair(32'hFFFF_FFF0, 32'hFFFF_FFFA, 16, 11, 1'b0, "R2 R3 R4 long");
        run_pair(32'hFFFF_FFFA, 32'hFFFF_FFFF, 6, 6, 1'b0, "R11 full");
        run_pair(32'hFFFF_FFFA, 32'h0000_0000, 6, 0, 1'b0, "R11 none");
        run_pair(32'hFFFF_FFFC, 32'hFFFF_FFFD, 4, 2, 1'b1, "R10");

        // R9: stop with invert set -> output held at 1
        cur_tag = "R9";
        tick(1'b1, 2'd2, 32'h2);
        for (int k = 0; k < 4; k++) begin
            chk("R9 stopped inverted", pwm_out, 1'b1);
            idle();
        end
        tick(1'b1, 2'd2, 32'h0);
        chk("R10 invert cleared next cycle", pwm_out, 1'b0);

        // R8: rewrite base/threshold mid-period; the current 10/3 period holds
        run_pair(32'hFFFF_FFF6, 32'hFFFF_FFF8, 10, 3, 1'b0, "R8 setup");
        cur_tag = "R8";
        tick(1'b1, 2'd2, 32'h0);
        tick(1'b1, 2'd2, 32'h1);
        for (int k = 0; k < 22; k++) begin
            chk("R8 mid-period write", pwm_out, (k < 10) ? (k < 3) : (((k - 10) % 4) < 2));
            if (k == 2)      tick(1'b1, 2'd0, 32'hFFFF_FFFC);
            else if (k == 3) tick(1'b1, 2'd1, 32'hFFFF_FFFD);
            else             idle();
        end

        // R12: repeated run=1 while running does not restart
        run_pair(32'hFFFF_FFF6, 32'hFFFF_FFF8, 10, 3, 1'b0, "R12 setup");
        cur_tag = "R12";
        tick(1'b1, 2'd2, 32'h0);
        tick(1'b1, 2'd2, 32'h1);
        for (int k = 0; k < 20; k++) begin
            chk("R12 no restart", pwm_out, (k % 10) < 3);
            if (k == 4) tick(1'b1, 2'd2, 32'h1);
            else        idle();
        end

        // R9: stop while running -> inactive from the next cycle
        tick(1'b1, 2'd2, 32'h0);
        cur_tag = "R9";
        for (int k = 0; k < 4; k++) begin
            chk("R9 stop", pwm_out, 1'b0);
            idle();
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule